// File: doc/BRIEF.md
# Program-Memory Table Read Unit

This block serves a table lookup instruction. It reads one 16-bit word from program memory and places the two halves of that word in two 8-bit registers. Software first loads a high index register and a low index register through their write ports. A lookup request then starts one memory read. The read uses the address made by joining the high index above the low index. When the memory returns the word, the unit places the low byte in the accumulator and the high byte in a separate result register, both in the same cycle.

The memory port is a plain synchronous interface. It has an address, a one-cycle read enable, a data-valid strobe and a 16-bit read bus. The memory may take one or more cycles to answer. If it answers in one cycle, the lookup completes on the second clock edge after the request. While a lookup is in flight the unit reports busy and drops any further request. The low index can be stepped by one through a separate input. That step wraps from 0xFF to 0x00 and never carries into the high index.

Top module: `tbl_read_unit`

## Requirements
- R1: After reset, busy, the read enable, the accumulator, the result register and both index registers are all zero.
- R2: The read address is bits 4..0 of the high index placed above all 8 bits of the low index, giving 13 bits. High index bits 7..5 have no effect on the address.
- R3: A request taken while idle raises the read enable for exactly one cycle, starting on the clock edge that samples the request. The address is presented in that same cycle.
- R4: On the edge that samples data-valid during a lookup, word bits 7..0 go to the accumulator and bits 15..8 go to the result register, both in the same cycle.
- R5: Busy rises on the edge that accepts a request and falls on the edge that writes the data. A request made while busy starts no read and leaves the address unchanged.
- R6: Index writes made during a lookup do not change that lookup's address. The next lookup uses the new values.
- R7: The step input adds one to the low index modulo 256 and never changes the high index. A low index write in the same cycle takes priority over the step.
- R8: Data-valid seen while idle leaves the accumulator and the result register unchanged.
- R9: An index write is visible on that index's output after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hi_wr | input | 1 | Write strobe for the high index |
| lo_wr | input | 1 | Write strobe for the low index |
| idx_wdata | input | 8 | Write data for both index registers |
| lo_step | input | 1 | Add one to the low index, no carry |
| lookup_req | input | 1 | Start a table read |
| mem_rvalid | input | 1 | Memory read data is valid |
| mem_rdata | input | 16 | Memory read word |
| mem_addr | output | 13 | Program-memory read address |
| mem_rd | output | 1 | One-cycle read enable |
| busy | output | 1 | Lookup in flight |
| hi_idx | output | 8 | High index register |
| lo_idx | output | 8 | Low index register |
| acc | output | 8 | Accumulator, receives the low byte |
| r_byte | output | 8 | Result register, receives the high byte |

## Verification
The lookup is run with several index pairs:
- One plain pair shows that the two index registers are joined in the right order.
- A pair with the high index at 0xFF shows that the upper high-index bits are dropped.
- The pairs give words whose two bytes differ, which exposes any byte swap.

Memory latencies of one and three cycles separate an output that waits for data-valid from one that assumes a fixed delay. A lookup that meets repeated requests and index writes while it runs shows that the address is held and the request is dropped. A step from 0xFF shows that the low index wraps without carrying. A stray data-valid seen while idle shows that the destination registers are guarded.

// File: rtl/tbl_read_unit.sv
module tbl_read_unit #(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_wr,
  input  logic              lo_wr,
  input  logic [7:0]        idx_wdata,
  input  logic              lo_step,
  input  logic              lookup_req,
  input  logic              mem_rvalid,
  input  logic [15:0]       mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              busy,
  output logic [7:0]        hi_idx,
  output logic [7:0]        lo_idx,
  output logic [7:0]        acc,
  output logic [7:0]        r_byte
);
  localparam int HI_USED = ADDR_W - 8;

  logic take, land;
  logic [ADDR_W-1:0] next_addr;

  assign take      = lookup_req && !busy;
  assign land      = busy && mem_rvalid;
  assign next_addr = {hi_idx[HI_USED-1:0], lo_idx};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_idx <= '0;
      lo_idx <= '0;
    end else begin
      if (hi_wr) hi_idx <= idx_wdata;
      if (lo_wr) lo_idx <= idx_wdata;
      else if (lo_step) lo_idx <= lo_idx + 8'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      mem_rd   <= 1'b0;
      mem_addr <= '0;
    end else begin
      mem_rd <= take;
      if (take) begin
        busy     <= 1'b1;
        mem_addr <= next_addr;
      end else if (land) begin
        busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= '0;
      r_byte <= '0;
    end else if (land) begin
      acc    <= mem_rdata[7:0];
      r_byte <= mem_rdata[15:8];
    end
  end

  // R3
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  // R3
  rd_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> busy);
  // R5
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_req && !busy) |=> (busy && mem_rd));
  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_rvalid) |=> $stable(mem_addr));
  // R4
  land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_rvalid) |=> (!busy && acc == $past(mem_rdata[7:0])
                              && r_byte == $past(mem_rdata[15:8])));
  // R8
  dest_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && mem_rvalid) |=> ($stable(acc) && $stable(r_byte)));
  // R7
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_wr |=> $stable(hi_idx));
endmodule

// File: tb/tbl_read_unit_bench.sv
module tbl_read_unit_bench;
  logic clk = 0, rst_n = 0;
  logic hi_wr = 0, lo_wr = 0, lo_step = 0, lookup_req = 0, mem_rvalid = 0;
  logic [7:0] idx_wdata = 0;
  logic [15:0] mem_rdata = 0;
  logic [12:0] mem_addr;
  logic mem_rd, busy;
  logic [7:0] hi_idx, lo_idx, acc, r_byte;
  int checks = 0, fails = 0;
  logic [7:0] exp_acc = 0, exp_r = 0;

  always #4 clk = ~clk;

  tbl_read_unit u_tbl_read_unit (
    .clk(clk), .rst_n(rst_n), .hi_wr(hi_wr), .lo_wr(lo_wr), .idx_wdata(idx_wdata),
    .lo_step(lo_step), .lookup_req(lookup_req), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd), .busy(busy),
    .hi_idx(hi_idx), .lo_idx(lo_idx), .acc(acc), .r_byte(r_byte));

  function automatic logic [15:0] word_at(input logic [12:0] a);
    return {a[12:5] ^ 8'hA5, a[7:0] + 8'h3C};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_hi(input logic [7:0] v);
    hi_wr = 1; idx_wdata = v; tick(); hi_wr = 0;
    chk("R9 hi_idx", hi_idx, v);
  endtask

  task automatic wr_lo(input logic [7:0] v);
    lo_wr = 1; idx_wdata = v; tick(); lo_wr = 0;
    chk("R9 lo_idx", lo_idx, v);
  endtask

  task automatic lookup(input int lat, input logic [12:0] exp_addr);
    lookup_req = 1; tick(); lookup_req = 0;
    chk("R3 mem_rd", mem_rd, 1);
    chk("R5 busy up", busy, 1);
    chk("R2 mem_addr", mem_addr, exp_addr);
    for (int i = 1; i < lat; i++) begin
      tick();
      chk("R3 rd drop", mem_rd, 0);
      chk("R5 busy hold", busy, 1);
    end
    mem_rvalid = 1; mem_rdata = word_at(mem_addr); tick(); mem_rvalid = 0;
    exp_acc = word_at(exp_addr) & 16'hFF;
    exp_r   = word_at(exp_addr) >> 8;
    chk("R4 acc", acc, exp_acc);
    chk("R4 r_byte", r_byte, exp_r);
    chk("R5 busy down", busy, 0);
  endtask

  task automatic t_reset();
    chk("R1 busy", busy, 0);
    chk("R1 mem_rd", mem_rd, 0);
    chk("R1 acc", acc, 0);
    chk("R1 r_byte", r_byte, 0);
    chk("R1 hi_idx", hi_idx, 0);
    chk("R1 lo_idx", lo_idx, 0);
  endtask

  task automatic t_basic();
    wr_hi(8'h12); wr_lo(8'h34);
    lookup(1, 13'h1234);
  endtask

  task automatic t_upper_dropped();
    wr_hi(8'hFF); wr_lo(8'h00);
    lookup(3, 13'h1F00);
    wr_hi(8'hE1); wr_lo(8'h5A);
    lookup(2, 13'h015A);
  endtask

  task automatic t_busy_reject();
    wr_hi(8'h03); wr_lo(8'h77);
    lookup_req = 1; tick(); lookup_req = 0;
    chk("R2 addr first", mem_addr, 13'h0377);
    lookup_req = 1; hi_wr = 1; idx_wdata = 8'h0A; tick(); hi_wr = 0;
    lo_wr = 1; idx_wdata = 8'hC8; tick(); lo_wr = 0; lookup_req = 0;
    chk("R5 no second rd", mem_rd, 0);
    chk("R6 addr held", mem_addr, 13'h0377);
    mem_rvalid = 1; mem_rdata = word_at(13'h0377); tick(); mem_rvalid = 0;
    chk("R4 acc first", acc, word_at(13'h0377) & 16'hFF);
    chk("R5 idle after", busy, 0);
    lookup(1, 13'h0AC8);
  endtask

  task automatic t_step();
    wr_hi(8'h07); wr_lo(8'hFF);
    lo_step = 1; tick(); lo_step = 0;
    chk("R7 lo wrap", lo_idx, 8'h00);
    chk("R7 hi no carry", hi_idx, 8'h07);
    lo_step = 1; tick(); lo_step = 0;
    chk("R7 lo inc", lo_idx, 8'h01);
    lo_step = 1; lo_wr = 1; idx_wdata = 8'h40; tick(); lo_step = 0; lo_wr = 0;
    chk("R7 write wins", lo_idx, 8'h40);
    lookup(1, 13'h0740);
  endtask

  task automatic t_idle_rvalid();
    mem_rvalid = 1; mem_rdata = 16'hDEAD; tick(); mem_rvalid = 0;
    chk("R8 acc kept", acc, exp_acc);
    chk("R8 r kept", r_byte, exp_r);
    chk("R8 busy", busy, 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    t_reset();
    t_basic();
    t_upper_dropped();
    t_busy_reject();
    t_step();
    t_idle_rvalid();
    finish_run();
  end
endmodule